// File: doc/BRIEF.md
# Searchable single-entry pipeline FIFO

This block is the one-slot buffer between the decode stage and the execute stage of a small pipelined processor. Decode pushes an instruction template into it, and execute reads the oldest template and then pops it. Execute can also flush the buffer when a branch is taken. Each template holds three things: an opcode tag, a destination register name, and two operand values.

The decode stage must not read a register that the buffered template is still going to write. For that check the block has a combinational search port. It takes a register name and reports whether the held template will write that register.

Within a cycle, reading and popping are ordered before searching and pushing. Two things follow from this. First, execute can free the slot in the same cycle that decode refills it, so the buffer moves one template per cycle. Second, a template that is leaving in the current cycle never causes a search hit. Only add and load templates write a register. Branch and store templates never produce a hit.

Top module: `pipe_search_fifo`

## Requirements
- R1: After reset the buffer is empty: `deq_rdy` is 0, `enq_rdy` is 1 and `srch_hit` is 0 for every query.
- R2: A push (`enq_en` while `enq_rdy`, without `clr`) into the empty buffer makes `deq_rdy` 1 from the next cycle. From then on, `first_op`, `first_dst`, `first_opa` and `first_opb` show the pushed fields.
- R3: `deq_rdy` is 1 only while the buffer is full. A pop (`deq_en` while full) without a push empties the buffer in the next cycle. A push and a pop in the same cycle keep the buffer full and replace its content, so one template per cycle flows through.
- R4: `clr` empties the buffer in the next cycle, whatever its state. It wins over a push made in the same cycle, and that push leaves nothing behind.
- R5: `srch_hit` is 1 only while the buffer is full, the held template writes a register, and `first_dst` equals `srch_reg`. Otherwise it is 0.
- R6: Opcode encoding is 2'b00 add, 2'b01 branch, 2'b10 load and 2'b11 store. Add and load write their destination. Branch and store write nothing, so they never produce a hit, whatever their `first_dst`.
- R7: The search sees the state after a pop in the same cycle and before a push in the same cycle. `srch_hit` is 0 while `deq_en` pops the entry, and a template pushed in the current cycle is not yet visible to the search.
- R8: A push while `enq_rdy` is 0 is ignored, and the held fields stay unchanged. A pop while empty is ignored, and the buffer stays empty.
- R9: `enq_rdy` is 1 when the buffer is empty. While the buffer is full, `enq_rdy` equals `deq_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enq_en | input | 1 | Push request |
| enq_op | input | 2 | Opcode tag of the pushed template |
| enq_dst | input | REG_W | Destination register of the pushed template |
| enq_opa | input | DATA_W | First operand of the pushed template |
| enq_opb | input | DATA_W | Second operand of the pushed template |
| enq_rdy | output | 1 | A push is accepted this cycle |
| deq_en | input | 1 | Pop request |
| deq_rdy | output | 1 | The buffer holds a template |
| first_op | output | 2 | Opcode tag of the held template |
| first_dst | output | REG_W | Destination register of the held template |
| first_opa | output | DATA_W | First operand of the held template |
| first_opb | output | DATA_W | Second operand of the held template |
| clr | input | 1 | Flush, with priority over a push |
| srch_reg | input | REG_W | Register name to search for |
| srch_hit | output | 1 | The held template will write `srch_reg` |

## Verification
The bench streams templates so that a push and a pop land in the same cycle on every beat. A buffer that offered `enq_rdy` only when empty would drop to half rate and fail the per-cycle content checks. It searches the register of the departing entry during a pop: a search that ignored the pop would report a false hit, which would stall decode for no reason. It also searches the register of an arriving template, which a search looking past the push would report early. Further cases flush with a push in the same cycle (a wrong priority would leave a stale entry), push while full without a pop (the data would be overwritten), and search branch and store templates whose destination field matches the query (a missing opcode filter would report a hit).

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  localparam int OP_W = 2;

  localparam logic [OP_W-1:0] OP_ADD   = 2'b00;
  localparam logic [OP_W-1:0] OP_BRZ   = 2'b01;
  localparam logic [OP_W-1:0] OP_LOAD  = 2'b10;
  localparam logic [OP_W-1:0] OP_STORE = 2'b11;

  // Only arithmetic and load templates commit a register result
  function automatic logic op_writes_reg(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_LOAD);
  endfunction

endpackage

// File: rtl/sfq_ctrl.sv
module sfq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enq_en,
  input  logic deq_en,
  input  logic clr,
  output logic full,
  output logic enq_rdy,
  output logic enq_fire,
  output logic deq_fire,
  output logic load
);

  logic full_q;
  logic full_d;
  logic full_ce;

  // Pop is ordered before push: a pop frees the slot for a push in the same cycle
  always_comb begin
    deq_fire = deq_en && full_q;
    enq_rdy  = !full_q || deq_fire;
    enq_fire = enq_en && enq_rdy;
    load     = enq_fire && !clr;
    full_d   = full_q;
    if (clr) begin
      full_d = 1'b0;
    end else if (enq_fire) begin
      full_d = 1'b1;
    end else if (deq_fire) begin
      full_d = 1'b0;
    end
    full_ce = clr || enq_fire || deq_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (full_ce) begin
      full_q <= full_d;
    end
  end

  assign full = full_q;

  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_en && enq_rdy && !clr) |=> full_q); // R2

  AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_en && full_q && !enq_en && !clr) |=> !full_q); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !full_q); // R4

  AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_q && deq_en && !enq_en) |=> !full_q); // R8

endmodule

// File: rtl/sfq_store.sv
module sfq_store #(
  parameter int W = 71
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] data_q;
  logic [W-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (load) begin
      data_d = din;
    end
  end

  // Payload flops carry no reset: the full flag qualifies them
  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= data_d;
    end
  end

  assign dout = data_q;

endmodule

// File: rtl/sfq_match.sv
module sfq_match #(
  parameter int REG_W = 5
) (
  input  logic                   full,
  input  logic                   deq_fire,
  input  logic [sfq_pkg::OP_W-1:0] op,
  input  logic [REG_W-1:0]       dst,
  input  logic [REG_W-1:0]       query,
  output logic                   hit
);

  logic [REG_W-1:0] bit_eq;

  for (genvar i = 0; i < REG_W; i++) begin : g_cmp
    assign bit_eq[i] = ~(dst[i] ^ query[i]);
  end

  // Search is ordered after the pop and before the push of the same cycle
  always_comb begin
    hit = full && !deq_fire && sfq_pkg::op_writes_reg(op) && (&bit_eq);
  end

endmodule

// File: rtl/pipe_search_fifo.sv
module pipe_search_fifo #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enq_en,
  input  logic [sfq_pkg::OP_W-1:0] enq_op,
  input  logic [REG_W-1:0]         enq_dst,
  input  logic [DATA_W-1:0]        enq_opa,
  input  logic [DATA_W-1:0]        enq_opb,
  output logic                     enq_rdy,
  input  logic                     deq_en,
  output logic                     deq_rdy,
  output logic [sfq_pkg::OP_W-1:0] first_op,
  output logic [REG_W-1:0]         first_dst,
  output logic [DATA_W-1:0]        first_opa,
  output logic [DATA_W-1:0]        first_opb,
  input  logic                     clr,
  input  logic [REG_W-1:0]         srch_reg,
  output logic                     srch_hit
);

  localparam int OPW = sfq_pkg::OP_W;
  localparam int PW  = OPW + REG_W + 2 * DATA_W;

  logic          full;
  logic          enq_fire;
  logic          deq_fire;
  logic          load;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;

  sfq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq_en   (enq_en),
    .deq_en   (deq_en),
    .clr      (clr),
    .full     (full),
    .enq_rdy  (enq_rdy),
    .enq_fire (enq_fire),
    .deq_fire (deq_fire),
    .load     (load)
  );

  assign pay_in = {enq_op, enq_dst, enq_opa, enq_opb};

  sfq_store #(.W(PW)) u_store (
    .clk  (clk),
    .load (load),
    .din  (pay_in),
    .dout (pay_out)
  );

  assign first_op  = pay_out[PW-1 -: OPW];
  assign first_dst = pay_out[2*DATA_W +: REG_W];
  assign first_opa = pay_out[DATA_W +: DATA_W];
  assign first_opb = pay_out[0 +: DATA_W];
  assign deq_rdy   = full;

  sfq_match #(.REG_W(REG_W)) u_match (
    .full     (full),
    .deq_fire (deq_fire),
    .op       (first_op),
    .dst      (first_dst),
    .query    (srch_reg),
    .hit      (srch_hit)
  );

  AST_HIT_MATCHES_DST: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> (deq_rdy && (first_dst == srch_reg))); // R5

  AST_HIT_ONLY_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> ((first_op == sfq_pkg::OP_ADD) || (first_op == sfq_pkg::OP_LOAD))); // R6

  AST_NO_HIT_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> !deq_en); // R7

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_rdy && !deq_en && !clr) |=> (deq_rdy && $stable(first_opa) && $stable(first_dst))); // R8

  AST_RDY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    deq_rdy |-> (enq_rdy == deq_en)); // R9

  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_en && enq_rdy && !clr) |=> (first_opb == $past(enq_opb))); // R2

endmodule

// File: tb/test_pipe_search_fifo.sv
module test_pipe_search_fifo;

  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              enq_en;
  logic [1:0]        enq_op;
  logic [REG_W-1:0]  enq_dst;
  logic [DATA_W-1:0] enq_opa;
  logic [DATA_W-1:0] enq_opb;
  logic              enq_rdy;
  logic              deq_en;
  logic              deq_rdy;
  logic [1:0]        first_op;
  logic [REG_W-1:0]  first_dst;
  logic [DATA_W-1:0] first_opa;
  logic [DATA_W-1:0] first_opb;
  logic              clr;
  logic [REG_W-1:0]  srch_reg;
  logic              srch_hit;

  int  n_chk;
  int  n_fail;
  bit  done;

  pipe_search_fifo #(.REG_W(REG_W), .DATA_W(DATA_W)) i_pipe_search_fifo (
    .clk(clk), .rst_n(rst_n),
    .enq_en(enq_en), .enq_op(enq_op), .enq_dst(enq_dst),
    .enq_opa(enq_opa), .enq_opb(enq_opb), .enq_rdy(enq_rdy),
    .deq_en(deq_en), .deq_rdy(deq_rdy),
    .first_op(first_op), .first_dst(first_dst),
    .first_opa(first_opa), .first_opb(first_opb),
    .clr(clr), .srch_reg(srch_reg), .srch_hit(srch_hit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs after a falling edge; outputs settle 2 ns later
  task automatic cyc(input logic en, input logic [1:0] op, input logic [REG_W-1:0] dst,
                     input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                     input logic dq, input logic cl, input logic [REG_W-1:0] q);
    @(negedge clk);
    enq_en = en; enq_op = op; enq_dst = dst; enq_opa = a; enq_opb = b;
    deq_en = dq; clr = cl; srch_reg = q;
    #2;
  endtask

  task automatic idle(input logic [REG_W-1:0] q);
    cyc(1'b0, 2'b00, '0, '0, '0, 1'b0, 1'b0, q);
  endtask

  task automatic t_reset;
    idle(5'd0);
    chk("R1 deq_rdy", 64'(deq_rdy), 64'd0);
    chk("R1 enq_rdy", 64'(enq_rdy), 64'd1);
    chk("R1 srch_hit", 64'(srch_hit), 64'd0);
  endtask

  task automatic t_push_search;
    cyc(1'b1, 2'b00, 5'd7, 32'h1111_0001, 32'h2222_0002, 1'b0, 1'b0, 5'd7);
    chk("R7 push not visible", 64'(srch_hit), 64'd0);
    idle(5'd7);
    chk("R2 deq_rdy", 64'(deq_rdy), 64'd1);
    chk("R2 first_op", 64'(first_op), 64'd0);
    chk("R2 first_dst", 64'(first_dst), 64'd7);
    chk("R2 first_opa", 64'(first_opa), 64'h1111_0001);
    chk("R2 first_opb", 64'(first_opb), 64'h2222_0002);
    chk("R9 enq_rdy full idle", 64'(enq_rdy), 64'd0);
    chk("R5 hit add", 64'(srch_hit), 64'd1);
    idle(5'd6);
    chk("R5 miss other reg", 64'(srch_hit), 64'd0);
    cyc(1'b0, 2'b00, '0, '0, '0, 1'b1, 1'b0, 5'd7);
    chk("R7 no hit on pop", 64'(srch_hit), 64'd0);
    chk("R9 enq_rdy on pop", 64'(enq_rdy), 64'd1);
    idle(5'd7);
    chk("R3 empty after pop", 64'(deq_rdy), 64'd0);
    chk("R5 empty no hit", 64'(srch_hit), 64'd0);
  endtask

  task automatic t_opcodes;
    cyc(1'b1, 2'b01, 5'd3, 32'h5, 32'h6, 1'b0, 1'b0, 5'd3);
    idle(5'd3);
    chk("R6 branch no hit", 64'(srch_hit), 64'd0);
    cyc(1'b1, 2'b11, 5'd4, 32'h7, 32'h8, 1'b1, 1'b0, 5'd4);
    idle(5'd4);
    chk("R6 store first_op", 64'(first_op), 64'd3);
    chk("R6 store no hit", 64'(srch_hit), 64'd0);
    cyc(1'b1, 2'b10, 5'd9, 32'h9, 32'hA, 1'b1, 1'b0, 5'd9);
    idle(5'd9);
    chk("R5 load hit", 64'(srch_hit), 64'd1);
    cyc(1'b0, 2'b00, '0, '0, '0, 1'b1, 1'b0, 5'd0);
    idle(5'd0);
    chk("R3 empty after load pop", 64'(deq_rdy), 64'd0);
  endtask

  task automatic t_stream;
    cyc(1'b1, 2'b00, 5'd1, 32'd100, 32'd200, 1'b0, 1'b0, 5'd0);
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b1, 2'b00, 5'(k + 1), 32'(100 + k), 32'(200 + k), 1'b1, 1'b0, 5'(k + 1));
      chk("R3 stream deq_rdy", 64'(deq_rdy), 64'd1);
      chk("R3 stream first_opa", 64'(first_opa), 64'(100 + k - 1));
      chk("R9 stream enq_rdy", 64'(enq_rdy), 64'd1);
      chk("R7 stream arriving no hit", 64'(srch_hit), 64'd0);
    end
    cyc(1'b0, 2'b00, '0, '0, '0, 1'b1, 1'b0, 5'd5);
    chk("R3 stream last opa", 64'(first_opa), 64'd104);
    chk("R7 last pop no hit", 64'(srch_hit), 64'd0);
    idle(5'd0);
    chk("R3 stream drained", 64'(deq_rdy), 64'd0);
  endtask

  task automatic t_clear;
    cyc(1'b1, 2'b00, 5'd12, 32'hAA, 32'hBB, 1'b0, 1'b1, 5'd0);
    idle(5'd12);
    chk("R4 clear beats push empty", 64'(deq_rdy), 64'd0);
    chk("R4 clear beats push hit", 64'(srch_hit), 64'd0);
    cyc(1'b1, 2'b00, 5'd12, 32'hAA, 32'hBB, 1'b0, 1'b0, 5'd0);
    cyc(1'b1, 2'b00, 5'd13, 32'hCC, 32'hDD, 1'b1, 1'b1, 5'd0);
    idle(5'd0);
    chk("R4 clear with push and pop", 64'(deq_rdy), 64'd0);
    cyc(1'b0, 2'b00, '0, '0, '0, 1'b0, 1'b1, 5'd0);
    idle(5'd0);
    chk("R4 clear when empty", 64'(deq_rdy), 64'd0);
  endtask

  task automatic t_ignored;
    cyc(1'b1, 2'b10, 5'd20, 32'h1234, 32'h5678, 1'b0, 1'b0, 5'd0);
    cyc(1'b1, 2'b00, 5'd21, 32'hDEAD, 32'hBEEF, 1'b0, 1'b0, 5'd0);
    chk("R9 rdy low when full", 64'(enq_rdy), 64'd0);
    idle(5'd20);
    chk("R8 opa kept", 64'(first_opa), 64'h1234);
    chk("R8 dst kept", 64'(first_dst), 64'd20);
    chk("R8 op kept", 64'(first_op), 64'd2);
    chk("R8 still full", 64'(deq_rdy), 64'd1);
    cyc(1'b0, 2'b00, '0, '0, '0, 1'b1, 1'b0, 5'd0);
    cyc(1'b0, 2'b00, '0, '0, '0, 1'b1, 1'b0, 5'd0);
    chk("R8 empty pop rdy", 64'(deq_rdy), 64'd0);
    idle(5'd0);
    chk("R8 empty after pop", 64'(deq_rdy), 64'd0);
    chk("R8 enq_rdy empty", 64'(enq_rdy), 64'd1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; enq_en = 1'b0; enq_op = '0; enq_dst = '0;
    enq_opa = '0; enq_opb = '0; deq_en = 1'b0; clr = 1'b0; srch_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_push_search();
    t_opcodes();
    t_stream();
    t_clear();
    t_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule